// File: doc/BRIEF.md
# Pulse and Quadrature Counter

This block counts events derived from two input pins, S0 and S1. In its two single-input modes it counts one polarity of edge on S0, either through an optional glitch filter or straight from the synchronized pin. S1 can optionally steer the count direction. In quadrature mode it decodes S0 and S1 as a two-phase encoder at four counts per cycle. It also flags any illegal transition in which both phases change at once.

The decoded up and down events feed two counters. The main counter runs between zero and a programmable limit (TOP), and a shadow copy of the limit is loaded into TOP each time the counter wraps. The auxiliary counter wraps freely at its full width. Each counter has its own event selection, so one can track, for example, only down steps while the other tracks both. The main counter can optionally reload to half of TOP on wrap, which gives hysteresis around the wrap point.

A flat register port sets the configuration and the counter values and reads them back. An interrupt flag register with set, clear and enable registers drives a single interrupt line.

Top module: `pulse_quad_counter`

## Requirements
- R1: After reset, CFG (address 0) reads 0x0680. Its fields are mode [1:0], falling-edge select [2], count-down [3], filter enable [4], hysteresis [5], S1-direction enable [6], main event select [8:7] and auxiliary event select [10:9]. CNT (address 1) reads 0, TOP (address 2) and TOPBUF (address 3) read all ones, AUX (address 4), FLAGS (address 5) and ENABLE (address 8) read 0, and irq is low.
- R2: In mode 0 (disabled), edges on S0 and S1 change neither counter.
- R3: In mode 1 (filtered single) and mode 2 (direct single), a rising edge on S0 is counted when bit 2 is clear, and a falling edge is counted when bit 2 is set.
- R4: In the single-input modes, bit 3 clear makes each counted edge an up event, and bit 3 set makes it a down event.
- R5: With bit 6 set in a single-input mode, S1 high keeps the direction given by bit 3, and S1 low reverses it.
- R6: With bit 4 set in mode 1, a level on S0 must persist for FILT_LEN sampling cycles before it is accepted, so shorter pulses are not counted. In mode 2, bit 4 has no effect.
- R7: In mode 3 the state {S1,S0} stepping 00→01→11→10→00 produces one up event per step, and the reverse order produces down events. Bit 2 swaps up and down, and bit 3 has no effect.
- R8: In mode 3, a change of both S0 and S1 in one sampling cycle sets FLAGS bit 2 and changes no counter.
- R9: An up event at CNT==TOP wraps CNT to 0 and sets FLAGS bit 0. A down event at CNT==0 wraps CNT to TOP and sets FLAGS bit 1. Either wrap copies TOPBUF into TOP, and the wrap value uses TOP as it was before the copy.
- R10: With bit 5 set, both wraps reload CNT with TOP/2, rounded down.
- R11: Event select encodings are 0 = up and down, 1 = up only, 2 = down only and 3 = none, applied separately to the main counter and the auxiliary counter. AUX wraps modulo 2^CW and sets no flag.
- R12: A write to FSET (address 6) sets the flags whose bits are 1, and a write to FCLR (address 7) clears them. A hardware or FSET set wins over FCLR in the same cycle. irq is high when any flag is set whose ENABLE bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_in | input | 1 | Count input, or phase A in quadrature mode |
| s1_in | input | 1 | Direction input, or phase B in quadrature mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CW = 8, FILT_LEN = 4 and two synchronizer stages. The 8-bit width brings the free-running auxiliary wrap at 0xFF within a single pulse. The short filter length lets a 2-cycle pulse be rejected and an 8-cycle pulse be accepted within a few dozen cycles. Writing a small TOP brings both wraps, the hand-over from TOPBUF and the half-TOP reload within reach of a few pulses each.

// File: rtl/pqc_pkg.sv
package pqc_pkg;

   localparam int REG_W  = 16;
   localparam int ADDR_W = 4;
   localparam int NFLAGS = 3;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_FILT   = 2'd1,
      MODE_DIRECT = 2'd2,
      MODE_QUAD   = 2'd3
   } pqc_mode_e;

   typedef enum logic [1:0] {
      EV_BOTH = 2'd0,
      EV_UP   = 2'd1,
      EV_DOWN = 2'd2,
      EV_NONE = 2'd3
   } pqc_evsel_e;

   typedef struct packed {
      pqc_evsel_e aux_ev;
      pqc_evsel_e main_ev;
      logic       s1dir;
      logic       hyst;
      logic       filt;
      logic       down;
      logic       neg;
      pqc_mode_e  mode;
   } pqc_cfg_t;

   localparam int CFG_W = $bits(pqc_cfg_t);

   localparam pqc_cfg_t CFG_RESET = '{
      aux_ev: EV_NONE, main_ev: EV_UP, s1dir: 1'b0, hyst: 1'b0,
      filt: 1'b0, down: 1'b0, neg: 1'b0, mode: MODE_OFF};

   localparam logic [ADDR_W-1:0] A_CFG    = 4'd0;
   localparam logic [ADDR_W-1:0] A_CNT    = 4'd1;
   localparam logic [ADDR_W-1:0] A_TOP    = 4'd2;
   localparam logic [ADDR_W-1:0] A_TOPBUF = 4'd3;
   localparam logic [ADDR_W-1:0] A_AUX    = 4'd4;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
   localparam logic [ADDR_W-1:0] A_FSET   = 4'd6;
   localparam logic [ADDR_W-1:0] A_FCLR   = 4'd7;
   localparam logic [ADDR_W-1:0] A_FEN    = 4'd8;

   localparam int FLG_OVF  = 0;
   localparam int FLG_UNF  = 1;
   localparam int FLG_QERR = 2;

endpackage

// File: rtl/pqc_sync.sv
module pqc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("pqc_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[i] <= '0;
         end else begin
            stage_q[i] <= (i == 0) ? d : stage_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pqc_glitch_filter.sv
module pqc_glitch_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);
   localparam int CW_F = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   if (FILT_LEN < 1) begin : g_bad_len
      $error("pqc_glitch_filter: FILT_LEN must be at least 1");
   end

   logic [CW_F-1:0] run_q;
   logic            filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         filt_q <= 1'b0;
      end else if (raw == filt_q) begin
         run_q <= '0;
      end else if (run_q == CW_F'(FILT_LEN-1)) begin
         run_q  <= '0;
         filt_q <= raw;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign filt = filt_q;
endmodule

// File: rtl/pqc_event_gen.sv
module pqc_event_gen
   import pqc_pkg::*;
#(
   parameter int FILT_LEN = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pqc_cfg_t  cfg,
   input  logic      s0,
   input  logic      s1,
   output logic      ev_up,
   output logic      ev_dn,
   output logic      q_err
);
   logic       s0_filt, s0_sel, s0_prev_q;
   logic [1:0] ph_cur, ph_prev_q, ph_diff;
   logic       single_mode, edge_hit, dir_down;
   logic       quad_up, quad_dn;

   pqc_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (s0),
      .filt (s0_filt)
   );

   assign s0_sel = (cfg.filt && cfg.mode == MODE_FILT) ? s0_filt : s0;

   // phase index: 00->0, 01->1, 11->2, 10->3 for {s1,s0}
   assign ph_cur  = {s1, s1 ^ s0};
   assign ph_diff = ph_cur - ph_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_prev_q <= 1'b0;
         ph_prev_q <= 2'd0;
      end else begin
         s0_prev_q <= s0_sel;
         ph_prev_q <= ph_cur;
      end
   end

   assign single_mode = (cfg.mode == MODE_FILT) || (cfg.mode == MODE_DIRECT);
   assign edge_hit    = cfg.neg ? (s0_prev_q && !s0_sel) : (!s0_prev_q && s0_sel);
   assign dir_down    = cfg.down ^ (cfg.s1dir && !s1);

   assign quad_up = (cfg.mode == MODE_QUAD) && (ph_diff == 2'd1);
   assign quad_dn = (cfg.mode == MODE_QUAD) && (ph_diff == 2'd3);

   always_comb begin
      ev_up = 1'b0;
      ev_dn = 1'b0;
      if (single_mode && edge_hit) begin
         ev_up = !dir_down;
         ev_dn = dir_down;
      end else if (quad_up || quad_dn) begin
         ev_up = quad_up ^ cfg.neg;
         ev_dn = quad_dn ^ cfg.neg;
      end
   end

   assign q_err = (cfg.mode == MODE_QUAD) && (ph_diff == 2'd2);
endmodule

// File: rtl/pqc_counter.sv
module pqc_counter
   import pqc_pkg::*;
#(
   parameter int CW       = 16,
   parameter bit WITH_TOP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up,
   input  logic          dn,
   input  pqc_evsel_e    sel,
   input  logic          hyst,
   input  logic [CW-1:0] top,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] cnt,
   output logic          wrap_ovf,
   output logic          wrap_unf
);
   logic          cnt_up, cnt_dn;
   logic [CW-1:0] cnt_q;

   assign cnt_up = up && (sel == EV_BOTH || sel == EV_UP);
   assign cnt_dn = dn && (sel == EV_BOTH || sel == EV_DOWN);

   if (WITH_TOP) begin : g_bounded
      logic          at_top, at_zero;
      logic [CW-1:0] half_top;

      assign at_top   = (cnt_q == top);
      assign at_zero  = (cnt_q == '0);
      assign half_top = top >> 1;
      assign wrap_ovf = !wr && cnt_up && at_top;
      assign wrap_unf = !wr && cnt_dn && at_zero;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (wr) begin
            cnt_q <= wdata;
         end else if (cnt_up) begin
            cnt_q <= at_top ? (hyst ? half_top : '0) : cnt_q + 1'b1;
         end else if (cnt_dn) begin
            cnt_q <= at_zero ? (hyst ? half_top : top) : cnt_q - 1'b1;
         end
      end
   end else begin : g_free
      logic unused_bounds;
      assign unused_bounds = ^{hyst, top};
      assign wrap_ovf = 1'b0;
      assign wrap_unf = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (wr) begin
            cnt_q <= wdata;
         end else if (cnt_up) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (cnt_dn) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
   import pqc_pkg::*;
#(
   parameter int CW          = 16,
   parameter int FILT_LEN    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s0_in,
   input  logic              s1_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq
);
   if (!(CW == 8 || CW == 16)) begin : g_bad_width
      $error("pulse_quad_counter: CW must be 8 or 16");
   end
   if (CW > REG_W) begin : g_bad_bus
      $error("pulse_quad_counter: CW exceeds register width");
   end

   pqc_cfg_t          cfg_q;
   logic [CW-1:0]     top_q, topbuf_q, cnt_q, aux_q;
   logic [NFLAGS-1:0] flags_q, fen_q, flags_n;
   logic [1:0]        pins_sync;
   logic              ev_up, ev_dn, q_err;
   logic              wrap_ovf, wrap_unf, aux_ovf_unused, aux_unf_unused;
   logic              wr_cfg, wr_cnt, wr_top, wr_topbuf, wr_aux;
   logic              wr_fset, wr_fclr, wr_fen;

   assign wr_cfg    = wr_en && (wr_addr == A_CFG);
   assign wr_cnt    = wr_en && (wr_addr == A_CNT);
   assign wr_top    = wr_en && (wr_addr == A_TOP);
   assign wr_topbuf = wr_en && (wr_addr == A_TOPBUF);
   assign wr_aux    = wr_en && (wr_addr == A_AUX);
   assign wr_fset   = wr_en && (wr_addr == A_FSET);
   assign wr_fclr   = wr_en && (wr_addr == A_FCLR);
   assign wr_fen    = wr_en && (wr_addr == A_FEN);

   pqc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({s1_in, s0_in}),
      .q    (pins_sync)
   );

   pqc_event_gen #(.FILT_LEN(FILT_LEN)) u_evgen (
      .clk  (clk),
      .rst_n(rst_n),
      .cfg  (cfg_q),
      .s0   (pins_sync[0]),
      .s1   (pins_sync[1]),
      .ev_up(ev_up),
      .ev_dn(ev_dn),
      .q_err(q_err)
   );

   pqc_counter #(.CW(CW), .WITH_TOP(1'b1)) u_main (
      .clk     (clk),
      .rst_n   (rst_n),
      .up      (ev_up),
      .dn      (ev_dn),
      .sel     (cfg_q.main_ev),
      .hyst    (cfg_q.hyst),
      .top     (top_q),
      .wr      (wr_cnt),
      .wdata   (wr_data[CW-1:0]),
      .cnt     (cnt_q),
      .wrap_ovf(wrap_ovf),
      .wrap_unf(wrap_unf)
   );

   pqc_counter #(.CW(CW), .WITH_TOP(1'b0)) u_aux (
      .clk     (clk),
      .rst_n   (rst_n),
      .up      (ev_up),
      .dn      (ev_dn),
      .sel     (cfg_q.aux_ev),
      .hyst    (1'b0),
      .top     ({CW{1'b1}}),
      .wr      (wr_aux),
      .wdata   (wr_data[CW-1:0]),
      .cnt     (aux_q),
      .wrap_ovf(aux_ovf_unused),
      .wrap_unf(aux_unf_unused)
   );

   always_comb begin
      flags_n = flags_q;
      if (wr_fclr) flags_n = flags_n & ~wr_data[NFLAGS-1:0];
      if (wr_fset) flags_n = flags_n | wr_data[NFLAGS-1:0];
      flags_n[FLG_OVF]  = flags_n[FLG_OVF]  | wrap_ovf;
      flags_n[FLG_UNF]  = flags_n[FLG_UNF]  | wrap_unf;
      flags_n[FLG_QERR] = flags_n[FLG_QERR] | q_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= CFG_RESET;
         top_q    <= '1;
         topbuf_q <= '1;
         flags_q  <= '0;
         fen_q    <= '0;
      end else begin
         flags_q <= flags_n;
         if (wr_cfg)    cfg_q    <= pqc_cfg_t'(wr_data[CFG_W-1:0]);
         if (wr_topbuf) topbuf_q <= wr_data[CW-1:0];
         if (wr_fen)    fen_q    <= wr_data[NFLAGS-1:0];
         if (wr_top)                     top_q <= wr_data[CW-1:0];
         else if (wrap_ovf || wrap_unf)  top_q <= topbuf_q;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CFG:    rd_data = REG_W'(cfg_q);
         A_CNT:    rd_data = REG_W'(cnt_q);
         A_TOP:    rd_data = REG_W'(top_q);
         A_TOPBUF: rd_data = REG_W'(topbuf_q);
         A_AUX:    rd_data = REG_W'(aux_q);
         A_FLAGS:  rd_data = REG_W'(flags_q);
         A_FEN:    rd_data = REG_W'(fen_q);
         default:  rd_data = '0;
      endcase
   end

   assign irq = |(flags_q & fen_q);
endmodule

// File: rtl/pqc_checker.sv
module pqc_checker
   import pqc_pkg::*;
#(
   parameter int CW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input pqc_cfg_t          cfg_q,
   input logic              ev_up,
   input logic              ev_dn,
   input logic              q_err,
   input logic              wrap_ovf,
   input logic              wrap_unf,
   input logic [CW-1:0]     cnt_q,
   input logic [CW-1:0]     aux_q,
   input logic [CW-1:0]     top_q,
   input logic [NFLAGS-1:0] flags_q
);
   assert_event_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_up && ev_dn));

   assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.mode == MODE_OFF && !wr_en) |=> ($stable(cnt_q) && $stable(aux_q)));

   assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_ovf |=> flags_q[FLG_OVF]);

   assert_unf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_unf |=> flags_q[FLG_UNF]);

   assert_ovf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_ovf && !cfg_q.hyst) |=> (cnt_q == '0));

   assert_qerr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_err |=> flags_q[FLG_QERR]);

   assert_hyst_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wrap_ovf || wrap_unf) && cfg_q.hyst) |=> (cnt_q == ($past(top_q) >> 1)));
endmodule

bind pulse_quad_counter pqc_checker #(.CW(CW)) u_pqc_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .cfg_q   (cfg_q),
   .ev_up   (ev_up),
   .ev_dn   (ev_dn),
   .q_err   (q_err),
   .wrap_ovf(wrap_ovf),
   .wrap_unf(wrap_unf),
   .cnt_q   (cnt_q),
   .aux_q   (aux_q),
   .top_q   (top_q),
   .flags_q (flags_q)
);

// File: tb/tb_pulse_quad_counter.sv
`timescale 1ns/1ps
module tb_pulse_quad_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s0_in = 1'b0, s1_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   pulse_quad_counter #(.CW(8), .FILT_LEN(4), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .s0_in(s0_in), .s1_in(s1_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   localparam logic [3:0] CFG = 0, CNT = 1, TOP = 2, TOPBUF = 3, AUX = 4,
                          FLAGS = 5, FSET = 6, FCLR = 7, FEN = 8;

   function automatic logic [15:0] cfgv(input logic [1:0] mode, input logic neg,
         input logic down, input logic filt, input logic hyst, input logic s1dir,
         input logic [1:0] mev, input logic [1:0] aev);
      return {5'b0, aev, mev, s1dir, hyst, filt, down, neg, mode};
   endfunction

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%h expected 0x%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [3:0] a, input logic [15:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic set_s0(input logic v);
      @(negedge clk); s0_in = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse(input int hi);
      @(negedge clk); s0_in = 1'b1;
      repeat (hi) @(negedge clk);
      s0_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic qstep(input logic b, input logic a);
      @(negedge clk); s1_in = b; s0_in = a;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_check("R1 cfg", CFG, 16'h0680);
      rd_check("R1 cnt", CNT, 16'h0000);
      rd_check("R1 top", TOP, 16'h00FF);
      rd_check("R1 topbuf", TOPBUF, 16'h00FF);
      rd_check("R1 aux", AUX, 16'h0000);
      rd_check("R1 flags", FLAGS, 16'h0000);
      check("R1 irq", {15'b0, irq}, 16'h0000);
   endtask

   task automatic t_disabled;
      wr(CFG, cfgv(2'd0, 0, 0, 0, 0, 0, 2'd0, 2'd0));
      pulse(4); pulse(4); pulse(4);
      rd_check("R2 cnt", CNT, 16'd0);
      rd_check("R2 aux", AUX, 16'd0);
   endtask

   task automatic t_single;
      wr(CFG, cfgv(2'd2, 0, 0, 0, 0, 0, 2'd0, 2'd3));
      wr(CNT, 16'd0);
      set_s0(1'b1);
      rd_check("R3 rising counted", CNT, 16'd1);
      set_s0(1'b0);
      rd_check("R3 falling ignored", CNT, 16'd1);
      wr(CFG, cfgv(2'd2, 1, 0, 0, 0, 0, 2'd0, 2'd3));
      set_s0(1'b1);
      rd_check("R3 neg rising ignored", CNT, 16'd1);
      set_s0(1'b0);
      rd_check("R3 neg falling counted", CNT, 16'd2);
   endtask

   task automatic t_direction;
      wr(CFG, cfgv(2'd2, 0, 1, 0, 0, 0, 2'd0, 2'd3));
      wr(CNT, 16'd10);
      pulse(4);
      rd_check("R4 count down", CNT, 16'd9);
      wr(CFG, cfgv(2'd2, 0, 0, 0, 0, 1, 2'd0, 2'd3));
      s1_in = 1'b0;
      pulse(4);
      rd_check("R5 s1 low reverses", CNT, 16'd8);
      s1_in = 1'b1;
      pulse(4);
      rd_check("R5 s1 high keeps", CNT, 16'd9);
      s1_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_filter;
      wr(CFG, cfgv(2'd1, 0, 0, 1, 0, 0, 2'd0, 2'd3));
      wr(CNT, 16'd0);
      pulse(2);
      rd_check("R6 short pulse rejected", CNT, 16'd0);
      pulse(8);
      rd_check("R6 long pulse accepted", CNT, 16'd1);
      wr(CFG, cfgv(2'd2, 0, 0, 1, 0, 0, 2'd0, 2'd3));
      pulse(2);
      rd_check("R6 filter bit ignored in direct mode", CNT, 16'd2);
   endtask

   task automatic t_quad;
      wr(CFG, cfgv(2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd3));
      wr(CNT, 16'd10);
      qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
      rd_check("R7 forward up", CNT, 16'd14);
      qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
      rd_check("R7 reverse down", CNT, 16'd10);
      wr(CFG, cfgv(2'd3, 0, 1, 0, 0, 0, 2'd0, 2'd3));
      qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
      rd_check("R7 down bit no effect", CNT, 16'd14);
      wr(CFG, cfgv(2'd3, 1, 0, 0, 0, 0, 2'd0, 2'd3));
      qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
      rd_check("R7 polarity inverts", CNT, 16'd10);
   endtask

   task automatic t_qerr;
      wr(FCLR, 16'h0007);
      qstep(1, 1);
      rd_check("R8 no count on illegal step", CNT, 16'd10);
      rd_check("R8 error flag", FLAGS, 16'h0004);
      wr(CFG, cfgv(2'd0, 0, 0, 0, 0, 0, 2'd0, 2'd3));
      qstep(0, 0);
      wr(FCLR, 16'h0007);
   endtask

   task automatic t_wrap;
      wr(CFG, cfgv(2'd2, 0, 0, 0, 0, 0, 2'd0, 2'd3));
      wr(TOP, 16'd5);
      wr(TOPBUF, 16'd9);
      wr(CNT, 16'd5);
      pulse(4);
      rd_check("R9 overflow to zero", CNT, 16'd0);
      rd_check("R9 overflow flag", FLAGS, 16'h0001);
      rd_check("R9 top loaded from buffer", TOP, 16'd9);
      wr(CFG, cfgv(2'd2, 0, 1, 0, 0, 0, 2'd0, 2'd3));
      pulse(4);
      rd_check("R9 underflow to top", CNT, 16'd9);
      rd_check("R9 underflow flag", FLAGS, 16'h0003);
      wr(FCLR, 16'h0007);
   endtask

   task automatic t_hyst;
      wr(CFG, cfgv(2'd2, 0, 0, 0, 1, 0, 2'd0, 2'd3));
      wr(CNT, 16'd9);
      pulse(4);
      rd_check("R10 overflow to half top", CNT, 16'd4);
      wr(CFG, cfgv(2'd2, 0, 1, 0, 1, 0, 2'd0, 2'd3));
      wr(CNT, 16'd0);
      pulse(4);
      rd_check("R10 underflow to half top", CNT, 16'd4);
      wr(FCLR, 16'h0007);
   endtask

   task automatic t_events;
      wr(CFG, cfgv(2'd2, 0, 0, 0, 0, 0, 2'd2, 2'd0));
      wr(CNT, 16'd3);
      wr(AUX, 16'd0);
      pulse(4);
      rd_check("R11 down-only main ignores up", CNT, 16'd3);
      rd_check("R11 aux both counts up", AUX, 16'd1);
      wr(CFG, cfgv(2'd2, 0, 1, 0, 0, 0, 2'd2, 2'd1));
      pulse(4);
      rd_check("R11 down-only main counts down", CNT, 16'd2);
      rd_check("R11 up-only aux ignores down", AUX, 16'd1);
      wr(CFG, cfgv(2'd2, 0, 0, 0, 0, 0, 2'd3, 2'd0));
      wr(AUX, 16'h00FF);
      pulse(4);
      rd_check("R11 none main holds", CNT, 16'd2);
      rd_check("R11 aux wraps", AUX, 16'd0);
      rd_check("R11 aux wrap sets no flag", FLAGS, 16'd0);
   endtask

   task automatic t_flags;
      wr(FCLR, 16'h0007);
      wr(FEN, 16'h0000);
      wr(FSET, 16'h0002);
      rd_check("R12 set via FSET", FLAGS, 16'h0002);
      check("R12 irq masked", {15'b0, irq}, 16'h0000);
      wr(FEN, 16'h0002);
      check("R12 irq enabled", {15'b0, irq}, 16'h0001);
      wr(FCLR, 16'h0002);
      rd_check("R12 clear via FCLR", FLAGS, 16'h0000);
      check("R12 irq drops", {15'b0, irq}, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_single();
      t_direction();
      t_filter();
      t_quad();
      t_qerr();
      t_wrap();
      t_hyst();
      t_events();
      t_flags();
      report();
      $finish;
   end
endmodule